// File: doc/BRIEF.md
# Power-on reset override controller

This block keeps a device in reset after power is applied. Reset is released once the oscillator-running flag has stayed high without a break for a fixed start-up time, 8 ms at the default settings. A host on a test or production line can skip that wait. It leaves the override enable bit at 1, which is its power-up value, and then drives a timed toggle pattern on the two raw serial pins. The block then enters override mode and drops reset at once, whether or not the oscillator is running.

The pattern works as follows. The data/chip-enable pin stays low. The clock pin then gives at least two high pulses, and each of them lasts at least the short minimum of 500 ns. The clock pin then stays low for at least the long minimum of 2000 ns. All widths are counted in cycles of a reference clock whose frequency is a parameter, and each count is rounded up. Both pins pass through a synchroniser before detection.

Writing 0 to the enable bit leaves override mode. It also blocks the pattern until software writes the bit back to 1. Once reset has been released, it stays released until power-good drops.

Top module: `por_override_ctl`

## Requirements
- R1: While powerGood is low, rstOut is 1, overrideActive is 0 and overrideEnable reads 1.
- R2: With no override, rstOut falls only after oscRun has been high for PWRUP_CYC consecutive cycles, where PWRUP_CYC = ceil(PWRUP_US * REF_CLK_KHZ / 1000). It stays 1 while oscRun is low.
- R3: A low cycle on oscRun before release restarts the start-up count from zero.
- R4: With overrideEnable = 1, a complete pattern sets overrideActive to 1 and drives rstOut to 0, even when oscRun is low.
- R5: Each of the two clock-pin high pulses must last at least PULSE_CYC = ceil(PULSE_NS * REF_CLK_KHZ / 1e6) cycles. A shorter high pulse restarts detection and prevents entry.
- R6: The final clock-pin low hold must last at least HOLD_CYC = ceil(HOLD_NS * REF_CLK_KHZ / 1e6) cycles before entry. A shorter hold prevents entry.
- R7: A high level on serDataCe at any point in the pattern restarts detection.
- R8: Writing 0 (cfgWrEn = 1, cfgWrData = 0) clears overrideActive on the next clock. While the bit is 0, a complete pattern has no effect.
- R9: Writing 1 re-arms the enable bit, after which a complete pattern enters override again.
- R10: Writing 0 when override is not active changes neither the start-up release nor the reset output.
- R11: Encodings: overrideActive 1 = override active, 0 = inactive. overrideEnable 1 = override possible, 0 = override cleared or blocked. oscRun 1 = oscillator running.
- R12: Once rstOut has fallen, it stays 0 until powerGood goes low, including when override is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| powerGood | input | 1 | Power-good, active high; low acts as asynchronous reset |
| oscRun | input | 1 | Oscillator running flag (1 = running) |
| serDataCe | input | 1 | Raw data / chip-enable pin |
| serClk | input | 1 | Raw serial clock pin |
| cfgWrEn | input | 1 | Write strobe for the override enable bit |
| cfgWrData | input | 1 | Value written to the override enable bit |
| rstOut | output | 1 | Internal reset, active high |
| overrideActive | output | 1 | Override mode status (1 = active) |
| overrideEnable | output | 1 | Override enable bit readback (1 = possible) |

## Verification
The start-up path is driven with an oscillator flag that runs without a break, with one that drops partway, and with an enable write of 0 in the middle. Sampling one cycle before and one cycle after the computed count separates an off-by-one release from a correct one. The pattern detector is swept over every combination of the two high-pulse widths and over a range of hold lengths, each just below, at and above its rounded-up minimum, so a wrong comparison edge in either window is caught. Further cases cover a chip-enable glitch, a pattern sent while the bit is cleared, and re-entry after re-arming.

// File: rtl/por_ovr_pkg.sv
package por_ovr_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic timerRun;   // start-up counter advances, else clears
    logic phaseRun;   // pin phase counter advances, else clears
  } dpCmd_t;

  typedef enum logic [2:0] {
    ST_HUNT  = 3'd0,
    ST_HIGH1 = 3'd1,
    ST_LOW1  = 3'd2,
    ST_HIGH2 = 3'd3,
    ST_HOLD  = 3'd4
  } patState_t;

endpackage

// File: rtl/por_ovr_sync.sv
module por_ovr_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  input  logic [WIDTH-1:0] rstVal,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        chain[s] <= rstVal;
      end else if (s == 0) begin
        chain[s] <= din;
      end else begin
        chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  end

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/por_ovr_datapath.sv
module por_ovr_datapath
  import por_ovr_pkg::*;
#(
  parameter int PULSE_CYC   = 25,
  parameter int HOLD_CYC    = 100,
  parameter int PWRUP_CYC   = 400000,
  parameter int SYNC_STAGES = 2
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   serDataCe,
  input  logic   serClk,
  input  dpCmd_t cmd,
  output logic   ceLow,
  output logic   sclRise,
  output logic   sclFall,
  output logic   pulseLong,
  output logic   holdLong,
  output logic   timerDone
);

  localparam int PH_CAP = (HOLD_CYC > PULSE_CYC) ? HOLD_CYC : PULSE_CYC;
  localparam int PH_W   = $clog2(PH_CAP + 1);
  localparam int TM_W   = $clog2(PWRUP_CYC);

  logic [1:0]      pinSync;
  logic            sclDly;
  logic [PH_W-1:0] phaseCnt;
  logic [TM_W-1:0] timerCnt;

  por_ovr_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rstN   (rstN),
    .din    ({serDataCe, serClk}),
    .rstVal (2'b10),
    .dout   (pinSync)
  );

  assign ceLow   = !pinSync[1];
  assign sclRise =  pinSync[0] && !sclDly;
  assign sclFall = !pinSync[0] &&  sclDly;

  // phaseCnt: cycles the synchronised clock pin has held its level
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclDly   <= 1'b0;
      phaseCnt <= '0;
    end else begin
      sclDly <= pinSync[0];
      if (!cmd.phaseRun) begin
        phaseCnt <= '0;
      end else if (pinSync[0] != sclDly) begin
        phaseCnt <= PH_W'(1);
      end else if (phaseCnt < PH_W'(PH_CAP)) begin
        phaseCnt <= phaseCnt + 1'b1;
      end
    end
  end

  // at a falling edge phaseCnt still holds the finished high width
  assign pulseLong = phaseCnt >= PH_W'(PULSE_CYC);
  // in the hold, the current low cycle is the (phaseCnt+1)-th
  assign holdLong  = phaseCnt >= PH_W'(HOLD_CYC - 1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timerCnt <= '0;
    end else if (!cmd.timerRun) begin
      timerCnt <= '0;
    end else if (timerCnt < TM_W'(PWRUP_CYC - 1)) begin
      timerCnt <= timerCnt + 1'b1;
    end
  end

  assign timerDone = timerCnt == TM_W'(PWRUP_CYC - 1);

endmodule

// File: rtl/por_ovr_control.sv
module por_ovr_control
  import por_ovr_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   oscRun,
  input  logic   cfgWrEn,
  input  logic   cfgWrData,
  input  logic   ceLow,
  input  logic   sclRise,
  input  logic   sclFall,
  input  logic   pulseLong,
  input  logic   holdLong,
  input  logic   timerDone,
  output dpCmd_t cmd,
  output logic   released,
  output logic   overrideActive,
  output logic   overrideEnable
);

  patState_t state, stateNxt;
  logic      clrWrite;
  logic      enterNow;

  assign clrWrite = cfgWrEn && !cfgWrData;
  assign enterNow = ceLow && (state == ST_HOLD) && !sclRise && holdLong
                    && overrideEnable && !clrWrite;

  always_comb begin
    cmd.timerRun = oscRun && !released;
    cmd.phaseRun = ceLow;
  end

  always_comb begin
    stateNxt = state;
    if (!ceLow) begin
      stateNxt = ST_HUNT;
    end else begin
      unique case (state)
        ST_HUNT:  if (sclRise) stateNxt = ST_HIGH1;
        ST_HIGH1: if (sclFall) stateNxt = pulseLong ? ST_LOW1 : ST_HUNT;
        ST_LOW1:  if (sclRise) stateNxt = ST_HIGH2;
        ST_HIGH2: if (sclFall) stateNxt = pulseLong ? ST_HOLD : ST_HUNT;
        ST_HOLD: begin
          if (sclRise)       stateNxt = ST_HIGH2;
          else if (holdLong) stateNxt = ST_HUNT;
        end
        default: stateNxt = ST_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state          <= ST_HUNT;
      overrideEnable <= 1'b1;
      overrideActive <= 1'b0;
      released       <= 1'b0;
    end else begin
      state <= stateNxt;
      if (cfgWrEn) overrideEnable <= cfgWrData;
      if (clrWrite)      overrideActive <= 1'b0;
      else if (enterNow) overrideActive <= 1'b1;
      if (enterNow || (timerDone && oscRun)) released <= 1'b1;
    end
  end

  AST_CLEAR_EXITS: assert property (@(posedge clk) disable iff (!rstN)
    clrWrite |=> !overrideActive && !overrideEnable);  // R8

  AST_ENTRY_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrideActive) |-> $past(overrideEnable));  // R9

  AST_ENTRY_AFTER_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrideActive) |-> $past(holdLong && ceLow));  // R6

  AST_OVR_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    overrideActive |-> released);  // R4

  AST_RELEASE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    released |=> released);  // R12

  AST_RELEASE_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(released) |-> overrideActive || $past(oscRun && timerDone));  // R2

endmodule

// File: rtl/por_override_ctl.sv
module por_override_ctl
  import por_ovr_pkg::*;
#(
  parameter int REF_CLK_KHZ = 50000,
  parameter int PULSE_NS    = 500,
  parameter int HOLD_NS     = 2000,
  parameter int PWRUP_US    = 8000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic powerGood,
  input  logic oscRun,
  input  logic serDataCe,
  input  logic serClk,
  input  logic cfgWrEn,
  input  logic cfgWrData,
  output logic rstOut,
  output logic overrideActive,
  output logic overrideEnable
);

  localparam longint PULSE_RAW = (longint'(PULSE_NS) * REF_CLK_KHZ + 999999) / 1000000;
  localparam longint HOLD_RAW  = (longint'(HOLD_NS)  * REF_CLK_KHZ + 999999) / 1000000;
  localparam longint PWRUP_RAW = (longint'(PWRUP_US) * REF_CLK_KHZ + 999) / 1000;
  localparam int PULSE_CYC = (PULSE_RAW < 1) ? 1 : int'(PULSE_RAW);
  localparam int HOLD_CYC  = (HOLD_RAW  < 2) ? 2 : int'(HOLD_RAW);
  localparam int PWRUP_CYC = (PWRUP_RAW < 2) ? 2 : int'(PWRUP_RAW);

  dpCmd_t cmd;
  logic   ceLow, sclRise, sclFall, pulseLong, holdLong, timerDone;
  logic   released;

  por_ovr_datapath #(
    .PULSE_CYC   (PULSE_CYC),
    .HOLD_CYC    (HOLD_CYC),
    .PWRUP_CYC   (PWRUP_CYC),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk       (clk),
    .rstN      (powerGood),
    .serDataCe (serDataCe),
    .serClk    (serClk),
    .cmd       (cmd),
    .ceLow     (ceLow),
    .sclRise   (sclRise),
    .sclFall   (sclFall),
    .pulseLong (pulseLong),
    .holdLong  (holdLong),
    .timerDone (timerDone)
  );

  por_ovr_control u_ctl (
    .clk            (clk),
    .rstN           (powerGood),
    .oscRun         (oscRun),
    .cfgWrEn        (cfgWrEn),
    .cfgWrData      (cfgWrData),
    .ceLow          (ceLow),
    .sclRise        (sclRise),
    .sclFall        (sclFall),
    .pulseLong      (pulseLong),
    .holdLong       (holdLong),
    .timerDone      (timerDone),
    .cmd            (cmd),
    .released       (released),
    .overrideActive (overrideActive),
    .overrideEnable (overrideEnable)
  );

  assign rstOut = !released;

endmodule

// File: tb/por_override_ctl_tb.sv
module por_override_ctl_tb;

  localparam int KHZ = 3000;
  // expected windows, computed from the requirement formulas
  localparam int P_EXP = (500 * KHZ + 999999) / 1000000;   // 2
  localparam int H_EXP = (2000 * KHZ + 999999) / 1000000;  // 6
  localparam int W_EXP = (8000 * KHZ + 999) / 1000;        // 24000

  logic clk = 1'b0;
  logic powerGood = 1'b0, oscRun = 1'b0, serDataCe = 1'b1, serClk = 1'b0;
  logic cfgWrEn = 1'b0, cfgWrData = 1'b0;
  logic rstOut, overrideActive, overrideEnable;
  int   errors = 0, checks = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  por_override_ctl #(.REF_CLK_KHZ(KHZ)) u_dut (
    .clk (clk), .powerGood (powerGood), .oscRun (oscRun),
    .serDataCe (serDataCe), .serClk (serClk),
    .cfgWrEn (cfgWrEn), .cfgWrData (cfgWrData),
    .rstOut (rstOut), .overrideActive (overrideActive),
    .overrideEnable (overrideEnable)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic writeEn(input logic v);
    cfgWrEn = 1'b1; cfgWrData = v;
    tick(1);
    cfgWrEn = 1'b0;
  endtask

  task automatic pattern(input int h1, input int h2, input int hold, input logic ceGlitch);
    serDataCe = 1'b0; serClk = 1'b0; tick(3);
    serClk = 1'b1; tick(h1);
    serClk = 1'b0; tick(2);
    serClk = 1'b1; tick(h2);
    serClk = 1'b0;
    if (ceGlitch) begin
      tick(3); serDataCe = 1'b1; tick(1); serDataCe = 1'b0;
    end
    tick(hold);
    serDataCe = 1'b1; tick(6);
  endtask

  task automatic powerCycle();
    powerGood = 1'b0; oscRun = 1'b0; tick(3);
    check("R1 rst", rstOut, 1'b1);
    check("R1 ovr", overrideActive, 1'b0);
    check("R1 en", overrideEnable, 1'b1);
    powerGood = 1'b1; tick(2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    powerCycle();
    tick(50);
    check("R2 osc stopped", rstOut, 1'b1);

    // R3: interrupted oscillator restarts the count
    oscRun = 1'b1; tick(W_EXP - 10);
    oscRun = 1'b0; tick(5);
    check("R3 still reset", rstOut, 1'b1);
    oscRun = 1'b1;
    tick(100);
    writeEn(1'b0);  // R10: clear in normal operation
    check("R10 en readback", overrideEnable, 1'b0);
    tick(W_EXP - 102);
    check("R2 one before", rstOut, 1'b1);
    tick(1);
    check("R2 released", rstOut, 1'b0);
    check("R10 no ovr", overrideActive, 1'b0);
    writeEn(1'b1); writeEn(1'b0); tick(3);
    check("R12 sticky", rstOut, 1'b0);

    // override path
    powerCycle();
    pattern(P_EXP, P_EXP, H_EXP, 1'b0);
    check("R4 ovr", overrideActive, 1'b1);
    check("R4 rst", rstOut, 1'b0);
    writeEn(1'b0);
    check("R8 cleared", overrideActive, 1'b0);
    check("R11 en zero", overrideEnable, 1'b0);
    check("R12 after clear", rstOut, 1'b0);
    pattern(P_EXP, P_EXP, H_EXP + 2, 1'b0);
    check("R8 blocked", overrideActive, 1'b0);
    writeEn(1'b1);
    check("R11 en one", overrideEnable, 1'b1);
    pattern(P_EXP, P_EXP, H_EXP, 1'b0);
    check("R9 re-entry", overrideActive, 1'b1);
    writeEn(1'b0); writeEn(1'b1);
    pattern(P_EXP, P_EXP, H_EXP + 4, 1'b1);
    check("R7 ce glitch", overrideActive, 1'b0);

    // R5 sweep over both high widths
    for (int a = 1; a <= P_EXP + 1; a++) begin
      for (int b = 1; b <= P_EXP + 1; b++) begin
        pattern(a, b, H_EXP + 1, 1'b0);
        check("R5 pulse sweep", overrideActive, (a >= P_EXP) && (b >= P_EXP));
        writeEn(1'b0); writeEn(1'b1);
      end
    end

    // R6 sweep over hold length
    for (int l = 1; l <= H_EXP + 2; l++) begin
      pattern(P_EXP, P_EXP + 1, l, 1'b0);
      check("R6 hold sweep", overrideActive, l >= H_EXP);
      writeEn(1'b0); writeEn(1'b1);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule